// File: doc/BRIEF.md
# Mode-Selectable Bit-Slice ALU

A purely combinational arithmetic/logic unit made of identical one-bit slices. A ripple carry links the slices from bit 0 up to the most significant bit. A mode input chooses between bitwise logic and two's-complement arithmetic. A two-bit select picks one of four operations inside each mode. The incoming carry is the carry into bit 0 for arithmetic.

Each slice may invert its A bit and may replace its B bit with zero. This lets one adder structure cover eight functions. In arithmetic mode the incoming carry also changes the operation:
- With the carry set, select 00 gives increment.
- Select 01 gives negate.
- Select 11 gives B minus A.

The unit drives the sum or logic result, the carry out of the most significant slice, and a signed-overflow flag.

Top module: `bitslice_alu`

## Requirements
- R1: When mode_i is 0 (logic), sel_i = 00 gives f_o = a_i and sel_i = 01 gives f_o = ~a_i, bitwise. sel_i[1] is S1 and sel_i[0] is S0.
- R2: When mode_i is 0, sel_i = 10 gives f_o = a_i ^ b_i and sel_i = 11 gives f_o = ~(a_i ^ b_i), bitwise.
- R3: When mode_i is 1 (arithmetic), sel_i = 00 gives {carry_o, f_o} = a_i + carry_i. sel_i = 01 gives {carry_o, f_o} = ~a_i + carry_i. With carry_i = 1, these are increment of A and two's-complement negation of A.
- R4: When mode_i is 1 and sel_i = 10, {carry_o, f_o} = a_i + b_i + carry_i, computed WIDTH+1 bits wide.
- R5: When mode_i is 1 and sel_i = 11, {carry_o, f_o} = ~a_i + b_i + carry_i. With carry_i = 1, f_o = b_i - a_i modulo 2^WIDTH, and carry_o = 1 exactly when b_i >= a_i (unsigned).
- R6: When mode_i is 0, carry_o and ovf_o are both 0, whatever the other inputs are.
- R7: When sel_i[1] is 0, b_i has no effect on any output, in either mode.
- R8: When mode_i is 1, ovf_o is 1 exactly when the two adder operands agree in sign and the sign of f_o differs from theirs. The operands are a_i (or ~a_i) and b_i (or 0).
- R9: When mode_i is 0, carry_i has no effect on f_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A, optionally complemented per slice |
| b_i | input | WIDTH | Operand B, used only when sel_i[1] is 1 |
| mode_i | input | 1 | 0 selects logic, 1 selects arithmetic |
| sel_i | input | 2 | Operation select within the mode |
| carry_i | input | 1 | Carry into bit 0 for arithmetic |
| f_o | output | WIDTH | Result |
| carry_o | output | 1 | Carry out of the most significant slice |
| ovf_o | output | 1 | Signed overflow, arithmetic mode only |

## Verification
All sixteen combinations of mode, select and incoming carry are driven with random operands. This separates every function from its neighbours, for example the inverted-A variants from the plain ones and the carry-modified variants from the unmodified ones.

Directed operands probe the long cases:
- all-ones plus one ripples the carry through every slice;
- negating zero and the most negative value exposes the carry and overflow ends;
- B minus A with B below, equal to and above A tells the borrow sense apart.

Paired stimuli change only B, or only the incoming carry, in the cases where that input must be ignored. They show that the output does not move.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_PASS  = 2'b00,
    SEL_INV   = 2'b01,
    SEL_MIX   = 2'b10,
    SEL_MIXN  = 2'b11
  } alu_sel_e;

  typedef struct packed {
    logic inv_a;
    logic use_b;
    logic arith;
  } slice_ctrl_t;

endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
  import alu_pkg::*;
(
  input  logic        mode_i,
  input  logic [1:0]  sel_i,
  output slice_ctrl_t ctrl_o
);

  alu_sel_e sel;

  always_comb begin
    sel          = alu_sel_e'(sel_i);
    ctrl_o       = '0;
    ctrl_o.arith = mode_i;
    unique case (sel)
      SEL_PASS: begin ctrl_o.inv_a = 1'b0; ctrl_o.use_b = 1'b0; end
      SEL_INV:  begin ctrl_o.inv_a = 1'b1; ctrl_o.use_b = 1'b0; end
      SEL_MIX:  begin ctrl_o.inv_a = 1'b0; ctrl_o.use_b = 1'b1; end
      SEL_MIXN: begin ctrl_o.inv_a = 1'b1; ctrl_o.use_b = 1'b1; end
      default:  begin ctrl_o.inv_a = 1'b0; ctrl_o.use_b = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic        a_i,
  input  logic        b_i,
  input  logic        carry_i,
  input  slice_ctrl_t ctrl_i,
  output logic        f_o,
  output logic        carry_o
);

  logic a_eff, b_eff, c_eff, half;

  always_comb begin
    a_eff   = a_i ^ ctrl_i.inv_a;
    b_eff   = b_i & ctrl_i.use_b;
    // incoming carry only matters for arithmetic
    c_eff   = carry_i & ctrl_i.arith;
    half    = a_eff ^ b_eff;
    f_o     = half ^ c_eff;
    carry_o = (ctrl_i.arith & a_eff & b_eff) | (half & c_eff);
  end

endmodule

// File: rtl/alu_ovf_detect.sv
module alu_ovf_detect (
  input  logic arith_i,
  input  logic carry_msb_in_i,
  input  logic carry_msb_out_i,
  output logic ovf_o
);

  assign ovf_o = arith_i & (carry_msb_in_i ^ carry_msb_out_i);

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             mode_i,
  input  logic [1:0]       sel_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] f_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  slice_ctrl_t      ctrl;
  logic [WIDTH:0]   chain;

  alu_ctrl_decode i_ctrl (
    .mode_i (mode_i),
    .sel_i  (sel_i),
    .ctrl_o (ctrl)
  );

  assign chain[0] = carry_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice i_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .carry_i (chain[i]),
      .ctrl_i  (ctrl),
      .f_o     (f_o[i]),
      .carry_o (chain[i+1])
    );
  end

  alu_ovf_detect i_ovf (
    .arith_i         (ctrl.arith),
    .carry_msb_in_i  (chain[MSB]),
    .carry_msb_out_i (chain[WIDTH]),
    .ovf_o           (ovf_o)
  );

  // chain[WIDTH] is gated to 0 by every slice in logic mode
  assign carry_o = chain[WIDTH];

endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             mode_i,
  input logic [1:0]       sel_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] f_o,
  input logic             carry_o,
  input logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] inc_ref;
  logic [WIDTH:0] add_ref;

  always_comb begin
    inc_ref = {1'b0, a_i} + {{WIDTH{1'b0}}, carry_i};
    add_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};

    if (!mode_i) AST_LOGIC_FLAGS_LOW: assert (!carry_o && !ovf_o); // R6
    if (!mode_i && sel_i == 2'b00) AST_PASS_A: assert (f_o == a_i); // R1
    if (!mode_i && sel_i == 2'b01) AST_INVERT_A: assert (f_o == ~a_i); // R1
    if (!mode_i && sel_i == 2'b10) AST_XOR_AB: assert (f_o == (a_i ^ b_i)); // R2
    if (mode_i && sel_i == 2'b00) AST_INCREMENT: assert ({carry_o, f_o} == inc_ref); // R3
    if (mode_i && sel_i == 2'b01 && carry_i) AST_NEGATE: assert (f_o == (~a_i + 1'b1)); // R3
    if (mode_i && sel_i == 2'b10) AST_ADD: assert ({carry_o, f_o} == add_ref); // R4
    if (mode_i && sel_i == 2'b10)
      AST_ADD_OVF: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (f_o[MSB] != a_i[MSB]))); // R8
  end

endmodule

bind bitslice_alu alu_checker #(.WIDTH(WIDTH)) i_alu_checker (
  .a_i     (a_i),
  .b_i     (b_i),
  .mode_i  (mode_i),
  .sel_i   (sel_i),
  .carry_i (carry_i),
  .f_o     (f_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o)
);

// File: tb/test_bitslice_alu.sv
`timescale 1ns/1ps
module test_bitslice_alu;

  localparam int W = 8;
  localparam int RAND_PER_COMBO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, f;
  logic         mode, cin, cout, ovf;
  logic [1:0]   sel;

  int checks = 0;
  int fails  = 0;

  bitslice_alu #(.WIDTH(W)) i_bitslice_alu (
    .a_i (a), .b_i (b), .mode_i (mode), .sel_i (sel), .carry_i (cin),
    .f_o (f), .carry_o (cout), .ovf_o (ovf)
  );

  function automatic string req_of(input logic m, input logic [1:0] s);
    if (!m) return (s[1] ? "R2" : "R1");
    case (s)
      2'b00, 2'b01: return "R3";
      2'b10:        return "R4";
      default:      return "R5";
    endcase
  endfunction

  // behavioural reference: integer arithmetic on the selected operands
  task automatic model(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic m,
                       input logic [1:0] s, input logic c,
                       output logic [W-1:0] ef, output logic ec, output logic eo);
    int unsigned opa, opb, tot;
    opa = s[0] ? ((~ia) & ((1 << W) - 1)) : ia;
    opb = s[1] ? ib : 0;
    if (!m) begin
      ef = W'(opa ^ opb);
      ec = 1'b0;
      eo = 1'b0;
    end else begin
      tot = opa + opb + c;
      ef  = W'(tot);
      ec  = tot[W];
      eo  = (opa[W-1] == opb[W-1]) && (ef[W-1] != opa[W-1]);
    end
  endtask

  task automatic check(input string tag, input logic [W-1:0] ef, input logic ec, input logic eo);
    checks++;
    if (f !== ef || cout !== ec || ovf !== eo) begin
      fails++;
      $display("FAIL %s: got f=%h c=%b v=%b exp f=%h c=%b v=%b (a=%h b=%h m=%b s=%b ci=%b)",
               tag, f, cout, ovf, ef, ec, eo, a, b, mode, sel, cin);
    end
  endtask

  task automatic apply(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic m,
                       input logic [1:0] s, input logic c, input string extra);
    logic [W-1:0] ef;
    logic ec, eo;
    @(posedge clk);
    a = ia; b = ib; mode = m; sel = s; cin = c;
    @(negedge clk);
    model(ia, ib, m, s, c, ef, ec, eo);
    check({req_of(m, s), extra}, ef, ec, eo);
    if (m) begin
      checks++;
      if (ovf !== eo) begin
        fails++;
        $display("FAIL R8: ovf got %b exp %b", ovf, eo);
      end
    end else begin
      checks++;
      if (cout !== 1'b0 || ovf !== 1'b0) begin
        fails++;
        $display("FAIL R6: carry/ovf got %b%b exp 00", cout, ovf);
      end
    end
  endtask

  // same stimulus with one input changed must give identical outputs
  task automatic same_out(input string tag, input logic [W-1:0] ia, input logic [W-1:0] ib1,
                          input logic [W-1:0] ib2, input logic m, input logic [1:0] s,
                          input logic c1, input logic c2);
    logic [W-1:0] f1;
    logic c_1, o_1;
    @(posedge clk);
    a = ia; b = ib1; mode = m; sel = s; cin = c1;
    @(negedge clk);
    f1 = f; c_1 = cout; o_1 = ovf;
    @(posedge clk);
    b = ib2; cin = c2;
    @(negedge clk);
    checks++;
    if (f !== f1 || cout !== c_1 || ovf !== o_1) begin
      fails++;
      $display("FAIL %s: got f=%h c=%b v=%b exp f=%h c=%b v=%b", tag, f, cout, ovf, f1, c_1, o_1);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    a = '0; b = '0; mode = 1'b0; sel = 2'b00; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle zeros", '0, 1'b0, 1'b0);

    for (int combo = 0; combo < 16; combo++) begin
      for (int k = 0; k < RAND_PER_COMBO; k++) begin
        apply(W'($urandom), W'($urandom), combo[3], combo[2:1], combo[0], "");
      end
    end

    // R4 full ripple
    apply(8'hFF, 8'h01, 1'b1, 2'b10, 1'b0, " ripple");
    apply(8'hFF, 8'h00, 1'b1, 2'b00, 1'b1, " R3 inc wrap");
    // R3 negate corners
    apply(8'h00, 8'h5A, 1'b1, 2'b01, 1'b1, " negate zero");
    apply(8'h80, 8'h00, 1'b1, 2'b01, 1'b1, " negate min R8");
    // R8 add overflow both signs
    apply(8'h7F, 8'h01, 1'b1, 2'b10, 1'b0, " pos ovf");
    apply(8'h80, 8'hFF, 1'b1, 2'b10, 1'b0, " neg ovf");
    // R5 B - A borrow sense
    apply(8'h30, 8'h10, 1'b1, 2'b11, 1'b1, " b<a");
    apply(8'h22, 8'h22, 1'b1, 2'b11, 1'b1, " b==a");
    apply(8'h10, 8'h30, 1'b1, 2'b11, 1'b1, " b>a");

    // R7 b ignored when sel_i[1]=0
    for (int s = 0; s < 2; s++) begin
      same_out("R7 logic", 8'hC3, 8'h00, 8'hFF, 1'b0, 2'(s), 1'b0, 1'b0);
      same_out("R7 arith", 8'hC3, 8'h00, 8'hFF, 1'b1, 2'(s), 1'b1, 1'b1);
    end
    // R9 carry_i ignored in logic mode
    for (int s = 0; s < 4; s++) begin
      same_out("R9", 8'h9C, 8'h35, 8'h35, 1'b0, 2'(s), 1'b0, 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule